// File: doc/BRIEF.md
# ADC Serial Readout Interface

This block is the digital side of a 16-bit sampling converter's serial port in a four-wire mode where the data output also works as an end-of-conversion flag. A host starts a conversion with a rising edge on the convert line while the select line is high. The block then releases its data output. It runs a conversion stub for a set number of clock cycles, captures the parallel result, and drives the output low to tell the host that data is ready. The host then clocks the result out with falling edges of the serial clock. The convert line must stay high for the whole frame. The output is released on the seventeenth falling clock edge, or earlier if the select line rises.

The select line may also be used to address other devices early in a conversion, but it has to be low from the minimum conversion time onwards. If it is not, the ready flag is never produced. The three host inputs are synchronised to the system clock and edge-detected. The output is presented as a data bit plus an output enable, and the enclosing system models the pull-up. Every host input change therefore reaches the port after a fixed pipeline of synchroniser stages plus one register.

Top module: `adc_readout_if`

## Requirements
- R1: A rising convert edge seen while select is high starts a conversion, and the output enable is low within three clock cycles.
- R2: A rising convert edge seen while select is low starts nothing. No ready flag appears afterwards and serial clock edges have no effect.
- R3: While idle, the output is enabled and driven to 0 when convert and select are both low, and released otherwise.
- R4: A conversion lasts CONV_CYC clock cycles, with the output released throughout. Afterwards the output is enabled and driven to 0 as the ready flag.
- R5: The parallel result is captured at the end of conversion. Later changes to conv_data_i do not alter the bits shifted out.
- R6: After the k-th falling serial clock edge of a readback (k = 1..16), the output carries result bit 16-k, so the most significant bit comes first.
- R7: The 17th falling serial clock edge releases the output.
- R8: A rising select edge during readback releases the output at once, before all bits are read.
- R9: If select is high at any cycle from MIN_CYC until the end of conversion, no ready flag is produced, and the output stays released until convert falls.
- R10: Select may be high during the first cycles of a conversion, before MIN_CYC, without affecting the ready flag or the data.
- R11: Convert falling at any point of a frame aborts it. The block returns to idle and the output follows the R3 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Conversion start; must stay high for the whole frame |
| sel_i | input | 1 | Select line from the host |
| sclk_i | input | 1 | Serial clock from the host |
| conv_data_i | input | DATA_W | Parallel result from the converter stub |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data output enable (0 = high impedance) |

## Verification
Random frames use random result words, random read lengths from one to seventeen clock edges, and random points where select is released early in the conversion. Each frame ends in one of three ways: a full read, a select rise, or a convert fall. This separates the three release paths and shows that bit order and result capture hold for every word. Directed cases cover the remaining start conditions: convert rising with select low, select held past the minimum time, and an abort during conversion. Each of these must yield no ready flag, which tells a missing start qualification apart from a missing window check.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2,
        ST_HOLD = 2'd3
    } fsm_state_e;

    typedef struct packed {
        fsm_state_e st;
        logic       oe;
    } ctrl_t;

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prv_o
);

    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES-1:0] pipe_d, pipe_q;
        logic              prev_d, prev_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], din_i[g]};
            prev_d = pipe_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '0;
                prev_q <= 1'b0;
            end else begin
                pipe_q <= pipe_d;
                prev_q <= prev_d;
            end
        end

        assign lvl_o[g] = pipe_q[STAGES-1];
        assign prv_o[g] = prev_q;
    end

endmodule

// File: rtl/adc_rd_conv_timer.sv
module adc_rd_conv_timer #(
    parameter int CONV_CYC = 40,
    parameter int MIN_CYC  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    input  logic sel_i,
    output logic done_o,
    output logic ok_o
);

    localparam int            CW    = $clog2(CONV_CYC + 1);
    localparam logic [CW-1:0] LAST  = CW'(CONV_CYC - 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic in_window;

    always_comb begin
        tmr_d     = tmr_q;
        in_window = (tmr_q.cnt >= MIN_V);
        if (start_i) begin
            tmr_d.cnt = '0;
            tmr_d.ok  = 1'b1;
        end else if (run_i) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
            if (in_window && sel_i) begin
                tmr_d.ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done_o = run_i && (tmr_q.cnt == LAST);
    assign ok_o   = tmr_q.ok && !(in_window && sel_i);

    // R4: the conversion count advances by one per cycle while running
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && !done_o) |=> (tmr_q.cnt == $past(tmr_q.cnt) + 1'b1));

    // R9: once the window is violated the result stays not-ok
    p_window_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && !ok_o) |=> !tmr_q.ok);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              step_i,
    output logic              bit_o,
    output logic              last_o
);

    localparam int            CW     = $clog2(DATA_W + 2);
    localparam logic [CW-1:0] ALL    = CW'(DATA_W);
    localparam logic [CW-1:0] END_V  = CW'(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CW-1:0]     cnt;
        logic              bitv;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.data = data_i;
            sh_d.cnt  = '0;
            sh_d.bitv = 1'b0;
        end else if (step_i) begin
            if (sh_q.cnt < ALL) begin
                sh_d.bitv = sh_q.data[DATA_W-1];
                sh_d.data = {sh_q.data[DATA_W-2:0], 1'b0};
                sh_d.cnt  = sh_q.cnt + 1'b1;
            end else if (sh_q.cnt == ALL) begin
                sh_d.bitv = 1'b0;
                sh_d.cnt  = END_V;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bit_o  = sh_q.bitv;
    assign last_o = (sh_q.cnt == END_V);

    // R6: each step presents the oldest unsent bit
    p_msb_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && sh_q.cnt < ALL) |=> (bit_o == $past(sh_q.data[DATA_W-1])));

    // R7: the step after the final data bit ends the frame
    p_frame_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && sh_q.cnt == ALL) |=> last_o);

endmodule

// File: rtl/adc_readout_if.sv
module adc_readout_if
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYC    = 40,
    parameter int MIN_CYC     = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_i,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int NLINES = 3;

    logic [NLINES-1:0] raw, lvl, prv;
    logic cnv_s, cnv_rise, sel_s, sel_rise, sck_fall;
    logic tmr_start, tmr_run, tmr_done, tmr_ok;
    logic sh_load, sh_step, sh_bit, sh_last;
    ctrl_t ctrl_d, ctrl_q;

    assign raw = {sclk_i, sel_i, cnv_i};

    adc_rd_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din_i (raw),
        .lvl_o (lvl),
        .prv_o (prv)
    );

    assign cnv_s    = lvl[0];
    assign cnv_rise = lvl[0] && !prv[0];
    assign sel_s    = lvl[1];
    assign sel_rise = lvl[1] && !prv[1];
    assign sck_fall = !lvl[2] && prv[2];

    adc_rd_conv_timer #(.CONV_CYC(CONV_CYC), .MIN_CYC(MIN_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .run_i   (tmr_run),
        .sel_i   (sel_s),
        .done_o  (tmr_done),
        .ok_o    (tmr_ok)
    );

    adc_rd_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .data_i (conv_data_i),
        .step_i (sh_step),
        .bit_o  (sh_bit),
        .last_o (sh_last)
    );

    assign tmr_run = (ctrl_q.st == ST_CONV);
    assign sh_step = (ctrl_q.st == ST_READ) && sck_fall;

    always_comb begin
        ctrl_d    = ctrl_q;
        tmr_start = 1'b0;
        sh_load   = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                ctrl_d.oe = !cnv_s && !sel_s;
                if (cnv_rise && sel_s) begin
                    ctrl_d.st = ST_CONV;
                    ctrl_d.oe = 1'b0;
                    tmr_start = 1'b1;
                end
            end
            ST_CONV: begin
                ctrl_d.oe = 1'b0;
                if (!cnv_s) begin
                    ctrl_d.st = ST_IDLE;
                    ctrl_d.oe = !sel_s;
                end else if (tmr_done) begin
                    sh_load = 1'b1;
                    if (tmr_ok) begin
                        ctrl_d.st = ST_READ;
                        ctrl_d.oe = 1'b1;
                    end else begin
                        ctrl_d.st = ST_HOLD;
                    end
                end
            end
            ST_READ: begin
                if (!cnv_s) begin
                    ctrl_d.st = ST_IDLE;
                    ctrl_d.oe = !sel_s;
                end else if (sel_rise || sh_last) begin
                    ctrl_d.st = ST_HOLD;
                    ctrl_d.oe = 1'b0;
                end
            end
            default: begin
                ctrl_d.oe = 1'b0;
                if (!cnv_s) begin
                    ctrl_d.st = ST_IDLE;
                    ctrl_d.oe = !sel_s;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, oe: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign sdo_o    = (ctrl_q.st == ST_READ) && sh_bit;
    assign sdo_oe_o = ctrl_q.oe;

    // R1: qualified start enters conversion with the output released
    p_start_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_IDLE && cnv_rise && sel_s) |=> (ctrl_q.st == ST_CONV && !sdo_oe_o));

    // R2: a start with select low stays idle and released
    p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_IDLE && cnv_rise && !sel_s) |=> (ctrl_q.st == ST_IDLE && !sdo_oe_o));

    // R4: the output always becomes enabled at a driven-low level
    p_busy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> !sdo_o);

    // R8: select rising during readback releases the output
    p_sel_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_READ && cnv_s && sel_rise) |=> !sdo_oe_o);

    // R9: a violated select window yields no ready flag
    p_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_CONV && cnv_s && tmr_done && !tmr_ok) |=> (!sdo_oe_o && ctrl_q.st == ST_HOLD));

    // R11: convert falling aborts any frame
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st != ST_IDLE && !cnv_s) |=> (ctrl_q.st == ST_IDLE));

endmodule

// File: tb/adc_readout_if_test.sv
module adc_readout_if_test;

    localparam int DATA_W   = 16;
    localparam int CONV_CYC = 40;
    localparam int MIN_CYC  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv = 1'b0, sel = 1'b0, sck = 1'b0;
    logic [DATA_W-1:0] cdata = '0;
    logic sdo, sdo_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    adc_readout_if #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .MIN_CYC(MIN_CYC)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnv_i       (cnv),
        .sel_i       (sel),
        .sclk_i      (sck),
        .conv_data_i (cdata),
        .sdo_o       (sdo),
        .sdo_oe_o    (sdo_oe)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected bit after the k-th falling edge: bit 16-k of the captured word
    function automatic logic exp_bit(input logic [DATA_W-1:0] w, input int k);
        return w[DATA_W - k];
    endfunction

    task automatic go_idle();
        cnv = 1'b0; sel = 1'b0; sck = 1'b0;
        wait_n(6);
    endtask

    task automatic start_conv(input int sel_hold);
        sel = 1'b1;
        wait_n(2);
        cnv = 1'b1;
        wait_n(sel_hold);
        sel = 1'b0;
    endtask

    // end_mode: 0 = cnv fall, 1 = sel rise
    task automatic frame(input logic [DATA_W-1:0] w, input int sel_hold,
                         input int nfall, input int end_mode);
        cdata = w;
        start_conv(sel_hold);
        chk("R1 released at start", {31'd0, sdo_oe}, 32'd0);
        wait_n(CONV_CYC - 2 - sel_hold);
        chk("R4 released during conversion", {31'd0, sdo_oe}, 32'd0);
        wait_n(10);
        chk("R4 ready flag enable", {31'd0, sdo_oe}, 32'd1);
        chk("R4 ready flag low", {31'd0, sdo}, 32'd0);
        cdata = ~w;  // R5: later input change must not reach the output
        for (int k = 1; k <= nfall; k++) begin
            sck = 1'b1; wait_n(4);
            sck = 1'b0; wait_n(5);
            if (k <= DATA_W) begin
                chk("R6 bit enable", {31'd0, sdo_oe}, 32'd1);
                chk("R6 R5 bit value", {31'd0, sdo}, {31'd0, exp_bit(w, k)});
            end else begin
                chk("R7 release on 17th edge", {31'd0, sdo_oe}, 32'd0);
            end
        end
        if (end_mode == 1 && nfall <= DATA_W) begin
            sel = 1'b1; wait_n(5);
            chk("R8 select rise releases", {31'd0, sdo_oe}, 32'd0);
            sck = 1'b1; wait_n(4); sck = 1'b0; wait_n(5);
            chk("R8 stays released", {31'd0, sdo_oe}, 32'd0);
        end
        sel = 1'b0; cnv = 1'b0; wait_n(6);
        chk("R11 R3 idle drive after frame", {30'd0, sdo_oe, sdo}, 32'd2);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        wait_n(3);
        chk("R3 reset state released", {31'd0, sdo_oe}, 32'd0);
        rst_n = 1'b1;
        wait_n(5);
        chk("R3 idle both low drives 0", {30'd0, sdo_oe, sdo}, 32'd2);
        sel = 1'b1; wait_n(5);
        chk("R3 idle select high releases", {31'd0, sdo_oe}, 32'd0);
        go_idle();

        // Directed full reads: extreme words, earliest and latest select release
        frame(16'hFFFF, 4, 17, 0);
        frame(16'h0001, 14, 17, 0);
        frame(16'h8000, 4, 16, 1);
        frame(16'hA5C3, 10, 3, 1);

        // R2: start with select low
        cdata = 16'h1234;
        cnv = 1'b1; wait_n(6);
        chk("R2 no start released", {31'd0, sdo_oe}, 32'd0);
        wait_n(CONV_CYC + 10);
        chk("R2 no ready flag", {31'd0, sdo_oe}, 32'd0);
        sck = 1'b1; wait_n(4); sck = 1'b0; wait_n(5);
        chk("R2 clock ignored", {31'd0, sdo_oe}, 32'd0);
        go_idle();

        // R9: select held high into the window
        cdata = 16'h5555;
        start_conv(30);
        wait_n(CONV_CYC + 10 - 30);
        chk("R9 no ready flag", {31'd0, sdo_oe}, 32'd0);
        sck = 1'b1; wait_n(4); sck = 1'b0; wait_n(5);
        chk("R9 stays released", {31'd0, sdo_oe}, 32'd0);
        go_idle();
        chk("R9 idle after convert fall", {30'd0, sdo_oe, sdo}, 32'd2);

        // R11: abort during conversion, then a fresh start with select low
        cdata = 16'h0F0F;
        start_conv(4);
        wait_n(6);
        cnv = 1'b0; wait_n(6);
        chk("R11 abort in conversion idle drive", {30'd0, sdo_oe, sdo}, 32'd2);
        cnv = 1'b1; wait_n(CONV_CYC + 10);
        chk("R11 aborted conversion gives no flag", {31'd0, sdo_oe}, 32'd0);
        go_idle();

        // R11: abort mid-readback then recover (R10 via random select release)
        for (int i = 0; i < 12; i++) begin
            logic [DATA_W-1:0] w;
            int nf, em, sh;
            w  = DATA_W'($urandom);
            nf = int'($urandom_range(17, 1));
            em = int'($urandom_range(1, 0));
            sh = int'($urandom_range(14, 4));
            frame(w, sh, nf, em);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule